// File: doc/BRIEF.md
# Ethernet Transmit Pad and FCS Inserter

This block is one stage of a transmit datapath, placed between the MAC client and the logic that faces the PHY. The client supplies one frame at a time as a byte stream. The stream begins with the destination address and ends with the last payload byte. The block passes these bytes through unchanged. VLAN tags of four or eight octets are carried like any other payload octet. If the frame is short, the block adds zero bytes after the payload until 60 bytes have gone out. It then appends the four-byte frame check sequence, so the smallest frame on the output is 64 bytes.

Both sides use a valid/ready byte stream with start-of-frame and end-of-frame markers. The output is a single register stage. Once the block has accepted the last client byte, it stops accepting input and produces the pad and FCS bytes on its own.

The controller has four states:
- `ST_IDLE` waits for a byte that carries the start marker.
- `ST_BODY` forwards client bytes.
- `ST_PAD` emits zero bytes.
- `ST_FCS` emits the four check bytes.

The transitions are:
- IDLE→BODY on a start byte without an end marker.
- IDLE or BODY→PAD on an end byte while fewer than 60 bytes have been emitted.
- IDLE or BODY→FCS on an end byte once 60 bytes have been emitted.
- PAD→FCS when the 60th byte is emitted.
- FCS→IDLE when the fourth check byte is loaded.

Top module: `eth_tx_padfcs`

## Requirements
- R1: Client bytes appear on `out_data` unchanged and in order, including any VLAN or stacked VLAN tag octets.
- R2: A frame with fewer than 60 client bytes is followed by 0x00 bytes until 60 bytes precede the FCS. A frame of 60 or more client bytes gets no pad byte.
- R3: The CRC uses polynomial 0x04C11DB7, processed in reflected form (0xEDB88320) with the least significant bit of each byte first. The register is preset to all ones at each frame start and covers every client and pad byte. The appended value is the complement of the final register.
- R4: The four FCS bytes follow the last client or pad byte. The low byte of the complemented register goes first, which puts the x^31 coefficient first on a serial line that sends the least significant bit first.
- R5: `in_ready` is low from the cycle after the end-marked client byte is accepted until every pad and FCS byte has been loaded into the output stage.
- R6: `out_sof` is high only on the first destination-address byte. `out_eof` is high only on the last FCS byte.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_sof` and `out_eof` hold their values on the next cycle.
- R8: A byte accepted in ST_IDLE without the start marker is dropped and produces no output.
- R9: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Client byte is valid |
| in_ready | output | 1 | Block accepts a client byte |
| in_data | input | 8 | Client byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last client byte of a frame |
| out_valid | output | 1 | Output byte is valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First byte of the output frame |
| out_eof | output | 1 | Last FCS byte of the output frame |

## Verification
The bench sends frames of 1, 14, 59, 60, 61 and 64 bytes. Lengths 59, 60 and 61 separate pad-by-one, exact-minimum and no-pad. A 64-byte frame confirms that long frames pass with no pad. A one-byte frame exercises the case where the start and end markers are on the same byte. Frames carrying single and stacked VLAN tags show that tag octets pass through untouched and are included in the CRC. The same frames are then repeated with random output stalls and input gaps, which exposes data loss or byte drift under backpressure. A stray byte with no start marker checks that nothing leaks out between frames.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BODY = 2'd1,
        ST_PAD  = 2'd2,
        ST_FCS  = 2'd3
    } txst_e;

    localparam int OCTET_W = 8;

endpackage

// File: rtl/eth_tx_crc.sv
module eth_tx_crc #(
    parameter int          CRC_W  = 32,
    parameter int          DATA_W = 8,
    parameter logic [31:0] POLY_R = 32'hEDB88320
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              step,
    input  logic [DATA_W-1:0] din,
    output logic [CRC_W-1:0]  crc_q
);

    logic [CRC_W-1:0] seed;
    logic [CRC_W-1:0] crc_nxt;

    // Reflected shift: one input bit per iteration, lsb of the byte first.
    function automatic logic [CRC_W-1:0] fold(input logic [CRC_W-1:0] c,
                                              input logic [DATA_W-1:0] d);
        logic [CRC_W-1:0] r;
        r = c;
        for (int b = 0; b < DATA_W; b++) begin
            if (r[0] ^ d[b]) r = (r >> 1) ^ POLY_R[CRC_W-1:0];
            else             r = r >> 1;
        end
        return r;
    endfunction

    always_comb begin
        seed    = start ? {CRC_W{1'b1}} : crc_q;
        crc_nxt = fold(seed, din);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    crc_q <= {CRC_W{1'b1}};
        else if (step) crc_q <= crc_nxt;
    end

endmodule

// File: rtl/eth_tx_len.sv
module eth_tx_len #(
    parameter int MIN_LEN = 60,
    localparam int CW     = $clog2(MIN_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic step,
    output logic below_next
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_after;

    // Count of bytes emitted once the present step completes; saturates.
    always_comb begin
        if (start)                          cnt_after = CW'(1);
        else if (cnt_q == CW'(MIN_LEN))     cnt_after = cnt_q;
        else                                cnt_after = cnt_q + CW'(1);
        below_next = (cnt_after < CW'(MIN_LEN));
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (step) cnt_q <= cnt_after;
    end

endmodule

// File: rtl/eth_tx_padfcs.sv
module eth_tx_padfcs #(
    parameter int DATA_W  = 8,
    parameter int CRC_W   = 32,
    parameter int MIN_LEN = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sof,
    output logic              out_eof
);
    import eth_tx_pkg::*;

    localparam int FCS_BYTES = CRC_W / DATA_W;
    localparam int IW        = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1;

    txst_e             state_q, state_nxt;
    logic [IW-1:0]     idx_q;
    logic              load;
    logic              emit, emit_sof, emit_eof;
    logic [DATA_W-1:0] emit_data;
    logic              crc_start, crc_step;
    logic              below_next;
    logic [CRC_W-1:0]  crc_q;
    logic [CRC_W-1:0]  fcs_word;
    logic [DATA_W-1:0] fcs_byte;

    logic              ov_q, osof_q, oeof_q;
    logic [DATA_W-1:0] od_q;

    eth_tx_crc #(.CRC_W(CRC_W), .DATA_W(DATA_W)) i_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .start (crc_start),
        .step  (crc_step),
        .din   (emit_data),
        .crc_q (crc_q)
    );

    eth_tx_len #(.MIN_LEN(MIN_LEN)) i_len (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (crc_start),
        .step       (crc_step),
        .below_next (below_next)
    );

    assign load     = !ov_q || out_ready;
    assign fcs_word = ~crc_q;
    assign fcs_byte = fcs_word[idx_q*DATA_W +: DATA_W];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    // Outputs and next state
    always_comb begin
        state_nxt = state_q;
        in_ready  = 1'b0;
        emit      = 1'b0;
        emit_sof  = 1'b0;
        emit_eof  = 1'b0;
        emit_data = '0;
        crc_start = 1'b0;
        crc_step  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready  = load;
                emit_data = in_data;
                if (in_valid && load && in_sof) begin
                    emit      = 1'b1;
                    emit_sof  = 1'b1;
                    crc_start = 1'b1;
                    crc_step  = 1'b1;
                    if (in_eof) state_nxt = below_next ? ST_PAD : ST_FCS;
                    else        state_nxt = ST_BODY;
                end
            end
            ST_BODY: begin
                in_ready  = load;
                emit_data = in_data;
                if (in_valid && load) begin
                    emit     = 1'b1;
                    crc_step = 1'b1;
                    if (in_eof) state_nxt = below_next ? ST_PAD : ST_FCS;
                end
            end
            ST_PAD: begin
                emit_data = '0;
                if (load) begin
                    emit     = 1'b1;
                    crc_step = 1'b1;
                    if (!below_next) state_nxt = ST_FCS;
                end
            end
            ST_FCS: begin
                emit_data = fcs_byte;
                if (load) begin
                    emit = 1'b1;
                    if (idx_q == IW'(FCS_BYTES - 1)) begin
                        emit_eof  = 1'b1;
                        state_nxt = ST_IDLE;
                    end
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                      idx_q <= '0;
        else if (state_q != ST_FCS)      idx_q <= '0;
        else if (load)                   idx_q <= idx_q + IW'(1);
    end

    // Output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_q   <= 1'b0;
            od_q   <= '0;
            osof_q <= 1'b0;
            oeof_q <= 1'b0;
        end else if (load) begin
            ov_q <= emit;
            if (emit) begin
                od_q   <= emit_data;
                osof_q <= emit_sof;
                oeof_q <= emit_eof;
            end
        end
    end

    assign out_valid = ov_q;
    assign out_data  = od_q;
    assign out_sof   = osof_q;
    assign out_eof   = oeof_q;

endmodule

// File: rtl/eth_tx_padfcs_chk.sv
module eth_tx_padfcs_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_sof,
    input logic              out_eof
);

    logic [15:0] olen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) olen_q <= '0;
        else if (out_valid && out_ready) begin
            if (out_eof)      olen_q <= '0;
            else if (out_sof) olen_q <= 16'd1;
            else if (olen_q != 16'hFFFF) olen_q <= olen_q + 16'd1;
        end
    end

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid); // R7

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> ($stable(out_data) && $stable(out_sof) && $stable(out_eof))); // R7

    AST_MIN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eof) |-> (olen_q >= 16'd63)); // R2

    AST_MARKER_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_sof && out_eof)); // R6

endmodule

bind eth_tx_padfcs eth_tx_padfcs_chk #(.DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sof   (out_sof),
    .out_eof   (out_eof)
);

// File: tb/test_eth_tx_padfcs.sv
module test_eth_tx_padfcs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_data;
    logic       out_sof;
    logic       out_eof;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [9:0] exp_q[$];
    string      tag_q[$];

    logic [15:0] lfsr = 16'hACE1;
    bit          bp_en = 0;

    always #4 clk = ~clk;

    eth_tx_padfcs i_eth_tx_padfcs (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int b = 0; b < 8; b++)
            r = (r[0] ^ d[b]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        return r;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Output ready pattern
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = bp_en ? (lfsr[0] | lfsr[3]) : 1'b1;
    end

    // Monitor / scoreboard
    bit         stall_prev = 0;
    logic [9:0] held = '0;
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (stall_prev)
                chk(out_valid && ({out_data, out_sof, out_eof} == held), "R7",
                    "held under stall", {21'd0, out_valid, out_data, out_sof, out_eof},
                    {21'd0, 1'b1, held});
            stall_prev = out_valid && !out_ready;
            held = {out_data, out_sof, out_eof};
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected output byte", {22'd0, held}, 32'd0);
                end else begin
                    logic [9:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(out_data == e[9:2], t, "data", {24'd0, out_data}, {24'd0, e[9:2]});
                    chk(out_sof == e[1], "R6", "sof marker", {31'd0, out_sof}, {31'd0, e[1]});
                    chk(out_eof == e[0], "R6", "eof marker", {31'd0, out_eof}, {31'd0, e[0]});
                end
            end
        end
    end

    task automatic put_byte(input logic [7:0] d, input logic s, input logic e, input int gap);
        repeat (gap) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        #1;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        if (e) begin
            @(negedge clk); #1;
            chk(!in_ready, "R5", "in_ready low during trailer", {31'd0, in_ready}, 32'd0);
        end
    endtask

    // Build expected output, then drive the frame
    task automatic send_frame(input int len, input int seed, input int vlan_tags, input bit gaps);
        logic [7:0]  fr[$];
        logic [31:0] c;
        int          n;
        for (int i = 0; i < len; i++) fr.push_back(8'((seed * 7 + i * 13) ^ (i >> 2)));
        for (int t = 0; t < vlan_tags && 12 + 4 * t + 3 < len; t++) begin
            fr[12 + 4 * t] = (t == vlan_tags - 1) ? 8'h81 : 8'h88;
            fr[13 + 4 * t] = (t == vlan_tags - 1) ? 8'h00 : 8'hA8;
        end
        n = (len < 60) ? 60 : len;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = (i < len) ? fr[i] : 8'h00;
            c = crc_byte(c, b);
            exp_q.push_back({b, (i == 0), 1'b0});
            tag_q.push_back((i < len) ? "R1" : "R2");
        end
        c = ~c;
        for (int k = 0; k < 4; k++) begin
            exp_q.push_back({c[8*k +: 8], 1'b0, (k == 3)});
            tag_q.push_back("R3_R4");
        end
        for (int i = 0; i < len; i++)
            put_byte(fr[i], (i == 0), (i == len - 1), gaps ? ((lfsr[1] & lfsr[5]) ? 1 : 0) : 0);
    endtask

    task automatic drain();
        int t;
        t = 0;
        while (exp_q.size() != 0 && t < 5000) begin @(negedge clk); t++; end
        chk(exp_q.size() == 0, "R1", "all expected bytes seen", exp_q.size(), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R9", "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        // R3: bench model sanity against the well-known check value
        begin
            logic [31:0] c;
            c = 32'hFFFFFFFF;
            for (int i = 0; i < 9; i++) c = crc_byte(c, 8'(8'h31 + i));
            chk(~c == 32'hCBF43926, "R3", "model check value", ~c, 32'hCBF43926);
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!out_valid, "R9", "out_valid after reset", {31'd0, out_valid}, 32'd0);
        chk(in_ready,   "R9", "in_ready after reset",  {31'd0, in_ready},  32'd1);

        send_frame(64, 1, 0, 0); drain();   // R1 exact long frame, no pad
        send_frame(14, 2, 0, 0); drain();   // R2 header only
        send_frame(1,  3, 0, 0); drain();   // R2 single byte, sof and eof together
        send_frame(59, 4, 0, 0); drain();   // R2 one pad byte
        send_frame(60, 5, 0, 0); drain();   // R2 exact minimum
        send_frame(61, 6, 0, 0); drain();   // R2 above minimum
        send_frame(18, 7, 1, 0); drain();   // R1 single VLAN tag
        send_frame(72, 8, 2, 0); drain();   // R1 stacked VLAN tags

        // R8: stray byte in idle without start marker
        put_byte(8'h5A, 1'b0, 1'b0, 0);
        repeat (20) @(negedge clk);
        #1;
        chk(!out_valid, "R8", "stray byte dropped", {31'd0, out_valid}, 32'd0);

        // R7: backpressure and input gaps, frames back to back
        bp_en = 1;
        send_frame(20, 9, 0, 1);
        send_frame(59, 10, 1, 1);
        send_frame(60, 11, 0, 1);
        send_frame(90, 12, 2, 1);
        send_frame(1, 13, 0, 1);
        drain();
        bp_en = 0;
        repeat (10) @(negedge clk);
        #1;
        chk(!out_valid, "R6", "idle after last frame", {31'd0, out_valid}, 32'd0);
        finish_run();
    end

endmodule